// File: doc/BRIEF.md
# Dual-Mode Host Register Bus Slave

This block lets a host processor read and write a small bank of internal byte registers over an asynchronous parallel bus. A static mode input picks one of two host bus styles. In strobe style the host uses separate active-low read and write strobes. In address-strobe style the host uses a single data strobe, and a direction line tells a read from a write. Both styles share one pin that latches the address. In strobe style that pin latches the address on a falling edge. In address-strobe style it latches on a rising edge. An active-low chip select gates every cycle. A single acknowledge output tells the host when the access is complete: it acts as a ready signal in one style and as a transfer acknowledge in the other.

Every host input is brought into the internal clock domain through a two-flop synchroniser before its edges are detected. The data bus is split into an input, an output and an output enable, so that the pad ring can build the bidirectional pins. The register bank has a fixed number of implemented registers. Accesses to addresses above that count are harmless.

Top module: `hbus_slave`

## Requirements
- R1: After reset, `ack` and `d_oe` are 0 and every implemented register reads back as 0x00.
- R2: With `mode_i`=0 (strobe style), the address on `addr_i` is latched when `ale_as` falls while `cs_n` is low. Later changes on `addr_i` do not affect the access.
- R3: With `mode_i`=1 (address-strobe style), the address on `addr_i` is latched when `ale_as` rises while `cs_n` is low. Later changes on `addr_i` do not affect the access.
- R4: While `cs_n` is high, no cycle is recognised. Strobes do not raise `ack` or `d_oe`, and they change no register.
- R5: In strobe style, a cycle begun by `wr_rw` falling stores the value present on `d_in` when `wr_rw` rises again. Earlier values of `d_in` during the strobe are discarded.
- R6: In address-strobe style, a cycle begins when `rd_ds_n` falls. The level of `wr_rw` at that moment sets the direction: 1 means read, 0 means write. A write stores `d_in` when `rd_ds_n` rises. A read changes no register.
- R7: With ACK_DELAY=2, `ack` is low after the third rising clock edge that follows a strobe's falling edge and high after the fourth. It stays high until the strobe or `cs_n` is released. It then goes low after the third rising edge that follows the release.
- R8: `d_oe` is 1 only during a read cycle. While it is 1, `d_out` carries the addressed register. `d_oe` stays 0 throughout write cycles and returns to 0 when the read ends.
- R9: Registers exist at addresses 0 to NUM_REGS-1 (16 by default). Reads of any higher address return 0x00, and writes to them change no register, including the register whose low address bits match.
- R10: If `cs_n` goes high before the write strobe is released, the write is abandoned and the target register keeps its old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 1 | Static bus style: 0 strobe style, 1 address-strobe style |
| cs_n | input | 1 | Active-low chip select |
| ale_as | input | 1 | Address latch (falling edge, style 0) or address strobe (rising edge, style 1) |
| rd_ds_n | input | 1 | Read strobe (style 0) or data strobe (style 1), active low |
| wr_rw | input | 1 | Write strobe, active low (style 0), or direction, 1 = read (style 1) |
| addr_i | input | 7 | Host address bus |
| d_in | input | 8 | Host data bus, input path |
| d_out | output | 8 | Host data bus, output path |
| d_oe | output | 1 | Data bus output enable |
| ack | output | 1 | Ready / transfer acknowledge |

## Verification
Every write and read is run in both bus styles. In each one, the address pins are moved to an unrelated value once the latch edge has passed, so a latch on the wrong edge or no latch at all shows up as a wrong read value. The acknowledge is sampled one cycle either side of its expected rise and fall, both after a strobe release and after a chip-select release, so an off-by-one delay is caught. Further patterns cover a write with changing data, strobes with chip select high, a write abandoned by chip select, and out-of-range writes. They separate a correct design from one that captures data early, ignores chip select, commits abandoned writes, or aliases high addresses onto real registers.

// File: rtl/hbus_pkg.sv
// Shared widths and mode encoding for the host register bus slave.
package hbus_pkg;
    localparam int HB_ADDR_W = 7;
    localparam int HB_DATA_W = 8;

    typedef enum logic {
        BUS_STROBE     = 1'b0,
        BUS_ADDRSTROBE = 1'b1
    } bus_mode_e;
endpackage

// File: rtl/hbus_sync.sv
// Two-flop synchroniser for a vector of asynchronous host inputs.
// Assumes each bit is sampled independently; multi-bit values must be held
// stable by the host around the edges that qualify them.
module hbus_sync #(
    parameter int   W       = 1,
    parameter logic RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    genvar b;
    generate
        for (b = 0; b < W; b++) begin : g_bit
            logic meta_q;
            logic stab_q;
            // two-stage capture of one asynchronous bit
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q <= RST_VAL;
                    stab_q <= RST_VAL;
                end else begin
                    meta_q <= async_i[b];
                    stab_q <= meta_q;
                end
            end
            assign sync_o[b] = stab_q;
        end
    endgenerate
endmodule

// File: rtl/hbus_ctrl.sv
// Bus cycle controller: detects edges on the synchronised host controls,
// latches the address, tracks one access at a time, times the acknowledge
// and issues single-cycle read and write pulses. Assumes mode_i is static
// and ACK_DELAY >= 2.
module hbus_ctrl
    import hbus_pkg::*;
#(
    parameter int ADDR_W    = HB_ADDR_W,
    parameter int ACK_DELAY = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_i,
    input  logic              cs_s,
    input  logic              ale_s,
    input  logic              rd_s,
    input  logic              wr_s,
    input  logic [ADDR_W-1:0] addr_s,
    output logic [ADDR_W-1:0] addr_q,
    output logic              wr_stb,
    output logic              rd_stb,
    output logic              ack,
    output logic              oe
);
    localparam int CNT_W = $clog2(ACK_DELAY + 1);

    logic             ale_d, rd_d, wr_d;
    logic             busy, is_wr;
    logic [CNT_W-1:0] cnt;
    logic             as_mode;
    logic             ale_fall, ale_rise, rd_fall, rd_rise, wr_fall, wr_rise;
    logic             start, start_wr, end_ok, abort;

    assign as_mode  = (bus_mode_e'(mode_i) == BUS_ADDRSTROBE);
    assign ale_fall = ale_d & ~ale_s;
    assign ale_rise = ~ale_d & ale_s;
    assign rd_fall  = rd_d & ~rd_s;
    assign rd_rise  = ~rd_d & rd_s;
    assign wr_fall  = wr_d & ~wr_s;
    assign wr_rise  = ~wr_d & wr_s;

    // start, direction, completion and abandonment of an access
    always_comb begin
        start    = ~busy & ~cs_s & (as_mode ? rd_fall : (rd_fall | wr_fall));
        start_wr = as_mode ? ~wr_s : wr_fall;
        end_ok   = busy & ~cs_s &
                   (as_mode ? rd_rise : (is_wr ? wr_rise : rd_rise));
        abort    = busy & cs_s;
    end

    assign wr_stb = end_ok & is_wr;
    assign rd_stb = start & ~start_wr;
    assign ack    = busy & (cnt == '0);
    assign oe     = busy & ~is_wr;

    // previous synchronised levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ale_d <= 1'b1;
            rd_d  <= 1'b1;
            wr_d  <= 1'b1;
        end else begin
            ale_d <= ale_s;
            rd_d  <= rd_s;
            wr_d  <= wr_s;
        end
    end

    // address latch on the mode-dependent edge of the shared latch pin
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (~cs_s & (as_mode ? ale_rise : ale_fall)) begin
            addr_q <= addr_s;
        end
    end

    // access tracking and acknowledge delay counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            is_wr <= 1'b0;
            cnt   <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            is_wr <= start_wr;
            cnt   <= CNT_W'(ACK_DELAY - 1);
        end else if (end_ok | abort) begin
            busy  <= 1'b0;
        end else if (busy && cnt != '0) begin
            cnt   <= cnt - CNT_W'(1);
        end
    end

    // R7: the acknowledge never appears in the first cycle of an access
    assert_ack_not_early_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !ack);
    // R7: releasing chip select drops the acknowledge one clock later
    assert_ack_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cs_s) |=> !ack);
    // R4: with chip select high an idle controller stays idle
    assert_cs_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s && !busy) |=> !busy);
    // R5: a write pulse lasts exactly one clock
    assert_wr_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);
    // R8: a read pulse lasts exactly one clock
    assert_rd_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> !rd_stb);
endmodule

// File: rtl/hbus_regs.sv
// Internal register bank: NUM_REGS byte registers, written by a single-cycle
// pulse, read into a holding register on a single-cycle read pulse.
// Assumes NUM_REGS <= 2**ADDR_W; higher addresses match no register.
module hbus_regs
    import hbus_pkg::*;
#(
    parameter int ADDR_W   = HB_ADDR_W,
    parameter int DATA_W   = HB_DATA_W,
    parameter int NUM_REGS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [NUM_REGS-1:0][DATA_W-1:0] mem;
    logic [DATA_W-1:0]               rd_val;

    genvar i;
    generate
        for (i = 0; i < NUM_REGS; i++) begin : g_reg
            // one register, loaded when the write pulse names it
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mem[i] <= '0;
                end else if (wr_en && addr == ADDR_W'(i)) begin
                    mem[i] <= wdata;
                end
            end
        end
    endgenerate

    // read multiplexer; an address with no register yields zero
    always_comb begin
        rd_val = '0;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (addr == ADDR_W'(k)) rd_val = mem[k];
        end
    end

    // hold the read value for the whole read cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_val;
        end
    end

    // R4: without a write pulse the bank keeps its contents
    assert_bank_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mem));
    // R9: a write above the implemented range changes nothing
    assert_oor_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(addr) >= NUM_REGS) |=> $stable(mem));
endmodule

// File: rtl/hbus_slave.sv
// Top of the dual-mode host register bus slave. Synchronises the host pins,
// runs the cycle controller and the register bank. The data bus is presented
// as separate input, output and enable for the pad ring. Assumes mode_i is
// static while the host is active.
module hbus_slave
    import hbus_pkg::*;
#(
    parameter int NUM_REGS  = 16,
    parameter int ACK_DELAY = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mode_i,
    input  logic                 cs_n,
    input  logic                 ale_as,
    input  logic                 rd_ds_n,
    input  logic                 wr_rw,
    input  logic [HB_ADDR_W-1:0] addr_i,
    input  logic [HB_DATA_W-1:0] d_in,
    output logic [HB_DATA_W-1:0] d_out,
    output logic                 d_oe,
    output logic                 ack
);
    localparam int BUS_W = HB_ADDR_W + HB_DATA_W;

    logic [3:0]           ctl_s;
    logic [BUS_W-1:0]     bus_s;
    logic [HB_ADDR_W-1:0] addr_q;
    logic                 wr_pulse, rd_pulse;

    hbus_sync #(.W(4), .RST_VAL(1'b1)) u_sync_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cs_n, ale_as, rd_ds_n, wr_rw}),
        .sync_o  (ctl_s)
    );

    hbus_sync #(.W(BUS_W), .RST_VAL(1'b0)) u_sync_bus (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({addr_i, d_in}),
        .sync_o  (bus_s)
    );

    hbus_ctrl #(.ADDR_W(HB_ADDR_W), .ACK_DELAY(ACK_DELAY)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode_i (mode_i),
        .cs_s   (ctl_s[3]),
        .ale_s  (ctl_s[2]),
        .rd_s   (ctl_s[1]),
        .wr_s   (ctl_s[0]),
        .addr_s (bus_s[BUS_W-1:HB_DATA_W]),
        .addr_q (addr_q),
        .wr_stb (wr_pulse),
        .rd_stb (rd_pulse),
        .ack    (ack),
        .oe     (d_oe)
    );

    hbus_regs #(.ADDR_W(HB_ADDR_W), .DATA_W(HB_DATA_W), .NUM_REGS(NUM_REGS)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (addr_q),
        .wr_en (wr_pulse),
        .rd_en (rd_pulse),
        .wdata (bus_s[HB_DATA_W-1:0]),
        .rdata (d_out)
    );

    // R8: the bus is only turned around by a read pulse
    assert_oe_from_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(d_oe) |-> $past(rd_pulse));
    // R8: a write commit never happens while the bus is driven
    assert_no_drive_on_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |-> !d_oe);
endmodule

// File: tb/sim_hbus_slave.sv
// Directed bench for hbus_slave: one task per scenario, each checks itself.
module sim_hbus_slave;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_i = 1'b0;
    logic       cs_n = 1'b1;
    logic       ale_as = 1'b1;
    logic       rd_ds_n = 1'b1;
    logic       wr_rw = 1'b1;
    logic [6:0] addr_i = '0;
    logic [7:0] d_in = '0;
    logic [7:0] d_out;
    logic       d_oe;
    logic       ack;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    hbus_slave u0 (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .cs_n(cs_n),
        .ale_as(ale_as), .rd_ds_n(rd_ds_n), .wr_rw(wr_rw), .addr_i(addr_i),
        .d_in(d_in), .d_out(d_out), .d_oe(d_oe), .ack(ack)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_ack(output bit seen);
        seen = 1'b0;
        for (int n = 0; n < 16 && !seen; n++) begin
            if (ack) seen = 1'b1; else tick(1);
        end
    endtask

    // address phase in either style, then scramble the address pins
    task automatic addr_phase(input logic [6:0] a);
        cs_n = 1'b0;
        addr_i = a;
        if (mode_i) ale_as = 1'b0; else ale_as = 1'b1;
        tick(3);
        ale_as = mode_i ? 1'b1 : 1'b0;
        tick(3);
        addr_i = 7'h55;
    endtask

    task automatic end_cycle();
        tick(4);
        cs_n = 1'b1;
        ale_as = 1'b1;
        wr_rw = 1'b1;
        tick(3);
    endtask

    task automatic bus_write(input logic [6:0] a, input logic [7:0] v, input string req);
        bit seen;
        addr_phase(a);
        d_in = v;
        if (mode_i) begin wr_rw = 1'b0; rd_ds_n = 1'b0; end
        else wr_rw = 1'b0;
        wait_ack(seen);
        check(seen, req, 0, 1);
        check(!d_oe, {req, " R8 no drive on write"}, d_oe, 0);
        if (mode_i) rd_ds_n = 1'b1; else wr_rw = 1'b1;
        end_cycle();
    endtask

    task automatic bus_read(input logic [6:0] a, output logic [7:0] v, output bit oe_seen);
        bit seen;
        addr_phase(a);
        if (mode_i) wr_rw = 1'b1;
        rd_ds_n = 1'b0;
        wait_ack(seen);
        v = d_out;
        oe_seen = d_oe & seen;
        rd_ds_n = 1'b1;
        tick(4);
        check(!d_oe, "R8 oe released", d_oe, 0);
        cs_n = 1'b1;
        tick(3);
    endtask

    task automatic expect_read(input logic [6:0] a, input logic [7:0] exp, input string req);
        logic [7:0] v;
        bit oe;
        bus_read(a, v, oe);
        check(oe, {req, " R8 oe during read"}, oe, 1);
        check(v == exp, req, v, exp);
    endtask

    task automatic t_reset();
        check(!ack, "R1 ack", ack, 0);
        check(!d_oe, "R1 d_oe", d_oe, 0);
        expect_read(7'd0, 8'h00, "R1 reg0");
        expect_read(7'd15, 8'h00, "R1 reg15");
    endtask

    task automatic t_strobe_rw();
        mode_i = 1'b0;
        bus_write(7'd2, 8'h3C, "R5 write ack");
        bus_write(7'd15, 8'hA5, "R5 write ack");
        expect_read(7'd2, 8'h3C, "R2 R5 readback 2");
        expect_read(7'd15, 8'hA5, "R2 R5 readback 15");
    endtask

    task automatic t_ack_timing();
        mode_i = 1'b0;
        addr_phase(7'd2);
        rd_ds_n = 1'b0;
        tick(3);
        check(!ack, "R7 ack low at edge 3", ack, 0);
        tick(1);
        check(ack, "R7 ack high at edge 4", ack, 1);
        check(d_oe && d_out == 8'h3C, "R8 data driven", d_out, 8'h3C);
        rd_ds_n = 1'b1;
        tick(2);
        check(ack, "R7 ack held at release edge 2", ack, 1);
        tick(1);
        check(!ack, "R7 ack low at release edge 3", ack, 0);
        end_cycle();
        // release by chip select instead of the strobe
        addr_phase(7'd2);
        rd_ds_n = 1'b0;
        tick(4);
        check(ack, "R7 ack high before cs release", ack, 1);
        cs_n = 1'b1;
        tick(2);
        check(ack, "R7 ack held at cs edge 2", ack, 1);
        tick(1);
        check(!ack && !d_oe, "R7 ack low at cs edge 3", ack, 0);
        rd_ds_n = 1'b1;
        tick(4);
    endtask

    task automatic t_data_at_rise();
        bit seen;
        mode_i = 1'b0;
        addr_phase(7'd6);
        d_in = 8'h01;
        wr_rw = 1'b0;
        wait_ack(seen);
        d_in = 8'hC7;
        tick(3);
        wr_rw = 1'b1;
        end_cycle();
        expect_read(7'd6, 8'hC7, "R5 value at strobe rise");
    endtask

    task automatic t_addr_strobe_mode();
        mode_i = 1'b1;
        bus_write(7'd7, 8'h77, "R6 write ack");
        expect_read(7'd7, 8'h77, "R3 R6 readback 7");
        d_in = 8'hFF;
        expect_read(7'd7, 8'h77, "R6 read changes nothing");
        expect_read(7'd2, 8'h3C, "R3 other reg");
        mode_i = 1'b0;
    endtask

    task automatic t_cs_gate();
        mode_i = 1'b0;
        bus_write(7'd3, 8'h5A, "R4 setup");
        addr_i = 7'd3;
        ale_as = 1'b0;
        tick(3);
        d_in = 8'hFF;
        wr_rw = 1'b0;
        tick(8);
        check(!ack, "R4 no ack without cs", ack, 0);
        wr_rw = 1'b1;
        rd_ds_n = 1'b0;
        tick(8);
        check(!ack && !d_oe, "R4 no read without cs", d_oe, 0);
        rd_ds_n = 1'b1;
        ale_as = 1'b1;
        tick(4);
        expect_read(7'd3, 8'h5A, "R4 reg unchanged");
    endtask

    task automatic t_out_of_range();
        mode_i = 1'b0;
        bus_write(7'd18, 8'hEE, "R9 oor write ack");
        bus_write(7'h7F, 8'hEE, "R9 oor write ack");
        expect_read(7'd18, 8'h00, "R9 oor reads zero");
        expect_read(7'd2, 8'h3C, "R9 no alias to 2");
        expect_read(7'd15, 8'hA5, "R9 no alias to 15");
    endtask

    task automatic t_abort();
        bit seen;
        mode_i = 1'b0;
        bus_write(7'd4, 8'h11, "R10 setup");
        addr_phase(7'd4);
        d_in = 8'h99;
        wr_rw = 1'b0;
        wait_ack(seen);
        check(seen, "R10 ack before abort", 0, 1);
        cs_n = 1'b1;
        tick(4);
        wr_rw = 1'b1;
        tick(4);
        ale_as = 1'b1;
        tick(3);
        expect_read(7'd4, 8'h11, "R10 abandoned write");
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(2);
        t_reset();
        t_strobe_rw();
        t_ack_timing();
        t_data_at_rise();
        t_addr_strobe_mode();
        t_cs_gate();
        t_out_of_range();
        t_abort();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule